// File: doc/BRIEF.md
# Wake-Up Power Management Controller

This block holds the power-state and wake control of a network controller. It keeps a 2-bit device power state, a PME enable bit and a sticky PME status bit. It decides when the PHY and the media-access logic are switched off. It filters three classes of wake event (fixed-pattern match, flexible-pattern match and link change) against the current power state. It drives an active-low power-management event pin whenever an accepted event is pending and enabled.

Two active-low resets feed the block. `aux_por_n` is the power-on reset from the auxiliary supply. `bus_rst_n` is the bus reset from main power. When a reset is released, the block samples the link-status input. A low sample means an auxiliary supply is present. That result then fixes several things: the capability word, whether a bus reset wipes the wake bits, whether PME enable comes up set after a power-on reset, and whether a bus reset counts as the D3cold state.

Three small state machines make up the control path:
- **Reset sampler.** It has the states HOLD and RUN. It enters HOLD on power-on reset or when `bus_rst_n` is low (RUN→HOLD). It moves HOLD→RUN on the first clock with both resets released, capturing the supply indication on that edge.
- **PHY power machine.** It has the states PHY_ON and PHY_OFF. ON→OFF is taken when a low-power request is present. OFF→ON is taken when the request is gone. Each move takes one clock.
- **Effective power state.** This is the state that gating uses: D0, D1, D2, D3HOT, D3COLD or OFF. It comes from the register, the reset condition and the supply indication.

Top module: `wake_pm_ctrl`

## Requirements
- R1: The control word is at address 0. The power state is in bits [1:0] (00 = D0, 01 = D1, 10 = D2, 11 = D3hot), PME enable is bit 8 and PME status is bit 15. After a power-on reset with link-status sampled high, the word reads 0, the capability word at address 1 bits [4:0] reads 01111b, `pme_n_o` is 1, and two clocks after release `phy_pwr_dn_o` is 0.
- R2: If link-status is sampled low when the power-on reset is released, the capability word reads 11111b (D3cold supported) and PME enable reads 1 with no software write.
- R3: Without an auxiliary supply, a bus reset clears PME enable and PME status and returns the power state to D0.
- R4: With an auxiliary supply, a bus reset leaves PME enable and PME status unchanged and returns the power state to D0. Register writes made while a bus reset is asserted are ignored.
- R5: `phy_pwr_dn_o` rises one clock after the effective state becomes D2, D3hot or D3cold with PME enable clear, or becomes OFF (bus reset without an auxiliary supply). In D0 and D1 it is always 0.
- R6: Setting PME enable while in D2 or D3hot brings `phy_pwr_dn_o` back to 0 one clock after the write takes effect.
- R7: Wake strobe bits are: bit 0 = fixed filter, bit 1 = flexible filter, bit 2 = link change. Fixed and link events are accepted in D0, D1, D2, D3hot and D3cold. Flexible events are accepted in D0 and D1, and in D2, D3hot and D3cold only when `ext_clk_strap_i` is 1.
- R8: An event is ignored, leaving PME status at 0, when PME enable is clear or when its class is not allowed in the current state.
- R9: An accepted event sets PME status at the next clock edge. `pme_n_o` is 0 exactly when PME status and PME enable are both 1.
- R10: Writing 1 to bit 15 clears PME status and writing 0 leaves it. When an accepted event and a clearing write arrive in the same cycle, the status stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| aux_por_n | input | 1 | Auxiliary-supply power-on reset, active low, asynchronous assert |
| bus_rst_n | input | 1 | Main-power bus reset, active low, sampled on the clock |
| link_stat_i | input | 1 | Link status, sampled at reset release (0 = auxiliary supply present) |
| ext_clk_strap_i | input | 1 | Strap: external clock available in low-power states |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control word, 1 capability word |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the selected register (combinational) |
| wake_evt_i | input | 3 | Wake strobes: [0] fixed, [1] flexible, [2] link change |
| phy_pwr_dn_o | output | 1 | 1 = PHY and media-access logic powered down |
| pme_n_o | output | 1 | Power-management event, active low |

## Verification
The hardest situation to reach is D3cold. It exists only while the bus reset is held after an auxiliary supply was detected. In that state the register port is deaf, so the only way to observe the state is through the wake pin and the bits left behind after release. The bench therefore starts from a power-on reset with link-status low and enables wake from D0. It then holds the bus reset, pulses one event class at a time, and checks `pme_n_o` during the reset. After release it reads back enable, status and the D0 state. A write issued in the middle of the reset shows that such writes are dropped. The whole sweep runs under both strap values and both supply conditions.

// File: rtl/wpm_pkg.sv
package wpm_pkg;

    localparam int REG_W       = 16;
    localparam int PS_W        = 2;
    localparam int N_WAKE      = 3;
    localparam int CAP_W       = 5;
    localparam int BIT_PME_EN  = 8;
    localparam int BIT_PME_STS = 15;

    localparam int WK_FIXED = 0;
    localparam int WK_FLEX  = 1;
    localparam int WK_LINK  = 2;

    localparam logic [CAP_W-1:0] CAP_NOAUX = 5'b01111;
    localparam logic [CAP_W-1:0] CAP_AUX   = 5'b11111;

    typedef enum logic [2:0] {
        EFF_D0,
        EFF_D1,
        EFF_D2,
        EFF_D3HOT,
        EFF_D3COLD,
        EFF_OFF
    } eff_state_e;

    // Effective power state seen by the wake gate and the PHY control.
    function automatic eff_state_e eff_state(input logic bus_rst_n,
                                             input logic in_hold,
                                             input logic aux_det,
                                             input logic [PS_W-1:0] ps);
        eff_state_e st;
        if (!bus_rst_n || in_hold) begin
            st = aux_det ? EFF_D3COLD : EFF_OFF;
        end else begin
            case (ps)
                2'b00:   st = EFF_D0;
                2'b01:   st = EFF_D1;
                2'b10:   st = EFF_D2;
                default: st = EFF_D3HOT;
            endcase
        end
        return st;
    endfunction

    // Whether wake class cls may raise status in state st.
    function automatic logic wake_allowed(input eff_state_e st,
                                          input int cls,
                                          input logic ext_clk);
        logic ok;
        case (st)
            EFF_D0, EFF_D1:                 ok = 1'b1;
            EFF_D2, EFF_D3HOT, EFF_D3COLD:  ok = (cls == WK_FLEX) ? ext_clk : 1'b1;
            default:                        ok = 1'b0;
        endcase
        return ok;
    endfunction

    // PHY and media-access logic may be switched off.
    function automatic logic wants_low_power(input eff_state_e st,
                                             input logic pme_en);
        logic lp;
        case (st)
            EFF_OFF:                        lp = 1'b1;
            EFF_D2, EFF_D3HOT, EFF_D3COLD:  lp = !pme_en;
            default:                        lp = 1'b0;
        endcase
        return lp;
    endfunction

endpackage

// File: rtl/wpm_rst_sampler.sv
module wpm_rst_sampler (
    input  logic clk,
    input  logic aux_por_n,
    input  logic bus_rst_n,
    input  logic link_stat_i,
    output logic aux_det_o,
    output logic sample_o,
    output logic fresh_o,
    output logic in_hold_o
);

    typedef enum logic {SMP_HOLD, SMP_RUN} smp_state_e;

    smp_state_e state_q, state_d;
    logic       aux_det_q;
    logic       fresh_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SMP_HOLD: if (bus_rst_n)  state_d = SMP_RUN;
            SMP_RUN:  if (!bus_rst_n) state_d = SMP_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge aux_por_n) begin
        if (!aux_por_n) state_q <= SMP_HOLD;
        else            state_q <= state_d;
    end

    // Supply indication and the "first release after power-on" flag.
    always_ff @(posedge clk or negedge aux_por_n) begin
        if (!aux_por_n) begin
            aux_det_q <= 1'b0;
            fresh_q   <= 1'b1;
        end else if (state_q == SMP_HOLD && bus_rst_n) begin
            aux_det_q <= !link_stat_i;
            fresh_q   <= 1'b0;
        end
    end

    always_comb begin
        aux_det_o = aux_det_q;
        fresh_o   = fresh_q;
        in_hold_o = (state_q == SMP_HOLD);
        sample_o  = (state_q == SMP_HOLD) && bus_rst_n;
    end

    a_r2_aux_capture: assert property (@(posedge clk) disable iff (!aux_por_n)
        (sample_o && !link_stat_i) |=> aux_det_o);

    a_r2_noaux_capture: assert property (@(posedge clk) disable iff (!aux_por_n)
        (sample_o && link_stat_i) |=> !aux_det_o);

endmodule

// File: rtl/wpm_pm_regs.sv
module wpm_pm_regs
    import wpm_pkg::*;
(
    input  logic              clk,
    input  logic              aux_por_n,
    input  logic              bus_rst_n,
    input  logic              aux_det_i,
    input  logic              sample_i,
    input  logic              fresh_i,
    input  logic              aux_new_i,
    input  logic              in_hold_i,
    input  logic              hit_i,
    input  logic              wr_i,
    input  logic              addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [PS_W-1:0]   pwr_state_o,
    output logic              pme_en_o,
    output logic              pme_sts_o
);

    logic [PS_W-1:0] ps_q;
    logic            pme_en_q;
    logic            pme_sts_q;
    logic            ctl_wr;
    logic            unused_wbits;

    assign ctl_wr       = wr_i && !in_hold_i && (addr_i == 1'b0);
    assign unused_wbits = ^{wdata_i[BIT_PME_STS-1:BIT_PME_EN+1],
                            wdata_i[BIT_PME_EN-1:PS_W]};

    always_ff @(posedge clk or negedge aux_por_n) begin
        if (!aux_por_n) begin
            ps_q      <= '0;
            pme_en_q  <= 1'b0;
            pme_sts_q <= 1'b0;
        end else if (!bus_rst_n) begin
            ps_q <= '0;
            if (!aux_det_i) begin
                pme_en_q  <= 1'b0;
                pme_sts_q <= 1'b0;
            end else if (hit_i) begin
                pme_sts_q <= 1'b1;
            end
        end else begin
            if (sample_i && fresh_i && aux_new_i) begin
                pme_en_q <= 1'b1;
            end else if (ctl_wr) begin
                ps_q     <= wdata_i[PS_W-1:0];
                pme_en_q <= wdata_i[BIT_PME_EN];
            end
            if (hit_i)
                pme_sts_q <= 1'b1;
            else if (ctl_wr && wdata_i[BIT_PME_STS])
                pme_sts_q <= 1'b0;
        end
    end

    assign pwr_state_o = ps_q;
    assign pme_en_o    = pme_en_q;
    assign pme_sts_o   = pme_sts_q;

    a_r3_busrst_clears: assert property (@(posedge clk) disable iff (!aux_por_n)
        (!bus_rst_n && !aux_det_i) |=> (!pme_en_q && !pme_sts_q));

    a_r4_busrst_keeps_en: assert property (@(posedge clk) disable iff (!aux_por_n)
        (!bus_rst_n && aux_det_i && pme_en_q) |=> pme_en_q);

    a_r2_default_enable: assert property (@(posedge clk) disable iff (!aux_por_n)
        (sample_i && fresh_i && aux_new_i) |=> pme_en_q);

    a_r8_no_spurious_status: assert property (@(posedge clk) disable iff (!aux_por_n)
        (!pme_sts_q && !hit_i) |=> !pme_sts_q);

    a_r10_hit_wins: assert property (@(posedge clk) disable iff (!aux_por_n)
        hit_i |=> pme_sts_q);

endmodule

// File: rtl/wpm_wake_gate.sv
module wpm_wake_gate
    import wpm_pkg::*;
#(
    parameter int NW = N_WAKE
) (
    input  eff_state_e       st_i,
    input  logic             ext_clk_i,
    input  logic             pme_en_i,
    input  logic [NW-1:0]    evt_i,
    output logic             hit_o
);

    logic [NW-1:0] acc;

    for (genvar g = 0; g < NW; g++) begin : g_cls
        assign acc[g] = evt_i[g] && pme_en_i && wake_allowed(st_i, g, ext_clk_i);
    end

    assign hit_o = |acc;

endmodule

// File: rtl/wpm_phy_fsm.sv
module wpm_phy_fsm (
    input  logic clk,
    input  logic aux_por_n,
    input  logic low_req_i,
    output logic phy_dn_o
);

    typedef enum logic {PHY_ON, PHY_OFF} phy_state_e;

    phy_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PHY_ON:  if (low_req_i)  state_d = PHY_OFF;
            PHY_OFF: if (!low_req_i) state_d = PHY_ON;
        endcase
    end

    always_ff @(posedge clk or negedge aux_por_n) begin
        if (!aux_por_n) state_q <= PHY_OFF;
        else            state_q <= state_d;
    end

    always_comb begin
        phy_dn_o = (state_q == PHY_OFF);
    end

    a_r5_enter_low: assert property (@(posedge clk) disable iff (!aux_por_n)
        low_req_i |=> phy_dn_o);

    a_r6_power_back: assert property (@(posedge clk) disable iff (!aux_por_n)
        !low_req_i |=> !phy_dn_o);

endmodule

// File: rtl/wake_pm_ctrl.sv
module wake_pm_ctrl
    import wpm_pkg::*;
(
    input  logic              clk,
    input  logic              aux_por_n,
    input  logic              bus_rst_n,
    input  logic              link_stat_i,
    input  logic              ext_clk_strap_i,
    input  logic              reg_wr_i,
    input  logic              reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    input  logic [N_WAKE-1:0] wake_evt_i,
    output logic              phy_pwr_dn_o,
    output logic              pme_n_o
);

    logic            aux_det, sample, fresh, in_hold;
    logic [PS_W-1:0] pwr_state;
    logic            pme_en, pme_sts;
    logic            hit;
    logic            low_req;
    eff_state_e      eff;

    wpm_rst_sampler u_smp (
        .clk         (clk),
        .aux_por_n   (aux_por_n),
        .bus_rst_n   (bus_rst_n),
        .link_stat_i (link_stat_i),
        .aux_det_o   (aux_det),
        .sample_o    (sample),
        .fresh_o     (fresh),
        .in_hold_o   (in_hold)
    );

    assign eff     = eff_state(bus_rst_n, in_hold, aux_det, pwr_state);
    assign low_req = wants_low_power(eff, pme_en);

    wpm_wake_gate #(.NW(N_WAKE)) u_gate (
        .st_i      (eff),
        .ext_clk_i (ext_clk_strap_i),
        .pme_en_i  (pme_en),
        .evt_i     (wake_evt_i),
        .hit_o     (hit)
    );

    wpm_pm_regs u_regs (
        .clk         (clk),
        .aux_por_n   (aux_por_n),
        .bus_rst_n   (bus_rst_n),
        .aux_det_i   (aux_det),
        .sample_i    (sample),
        .fresh_i     (fresh),
        .aux_new_i   (!link_stat_i),
        .in_hold_i   (in_hold),
        .hit_i       (hit),
        .wr_i        (reg_wr_i),
        .addr_i      (reg_addr_i),
        .wdata_i     (reg_wdata_i),
        .pwr_state_o (pwr_state),
        .pme_en_o    (pme_en),
        .pme_sts_o   (pme_sts)
    );

    wpm_phy_fsm u_phy (
        .clk       (clk),
        .aux_por_n (aux_por_n),
        .low_req_i (low_req),
        .phy_dn_o  (phy_pwr_dn_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == 1'b0) begin
            reg_rdata_o[PS_W-1:0]    = pwr_state;
            reg_rdata_o[BIT_PME_EN]  = pme_en;
            reg_rdata_o[BIT_PME_STS] = pme_sts;
        end else begin
            reg_rdata_o[CAP_W-1:0] = aux_det ? CAP_AUX : CAP_NOAUX;
        end
    end

    assign pme_n_o = !(pme_sts && pme_en);

    a_r5_d0_d1_powered: assert property (@(posedge clk) disable iff (!aux_por_n)
        (bus_rst_n && !in_hold && !pwr_state[1]) |=> !phy_pwr_dn_o);

    a_r9_event_drives_pin: assert property (@(posedge clk) disable iff (!aux_por_n)
        (hit && !(reg_wr_i && !reg_addr_i)) |=> !pme_n_o);

endmodule

// File: tb/wake_pm_ctrl_tb.sv
`timescale 1ns/1ps
module wake_pm_ctrl_tb;

    logic        clk = 1'b0;
    logic        aux_por_n = 1'b0;
    logic        bus_rst_n = 1'b1;
    logic        link_stat_i = 1'b1;
    logic        ext_clk_strap_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic        reg_addr_i = 1'b0;
    logic [15:0] reg_wdata_i = '0;
    logic [15:0] reg_rdata_o;
    logic [2:0]  wake_evt_i = '0;
    logic        phy_pwr_dn_o;
    logic        pme_n_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    wake_pm_ctrl u_dut (
        .clk             (clk),
        .aux_por_n       (aux_por_n),
        .bus_rst_n       (bus_rst_n),
        .link_stat_i     (link_stat_i),
        .ext_clk_strap_i (ext_clk_strap_i),
        .reg_wr_i        (reg_wr_i),
        .reg_addr_i      (reg_addr_i),
        .reg_wdata_i     (reg_wdata_i),
        .reg_rdata_o     (reg_rdata_o),
        .wake_evt_i      (wake_evt_i),
        .phy_pwr_dn_o    (phy_pwr_dn_o),
        .pme_n_o         (pme_n_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // st: 0..3 register states, 4 = D3cold
    function automatic int allow(input int st, input int cls, input bit ext, input bit aux);
        if (st == 4 && !aux) return 0;
        if (cls == 1 && st >= 2) return int'(ext);
        return 1;
    endfunction

    task automatic wr(input logic a, input logic [15:0] d);
        @(negedge clk);
        reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
        @(negedge clk);
        reg_wr_i = 1'b0; reg_addr_i = 1'b0;
    endtask

    task automatic pulse(input int cls);
        @(negedge clk);
        wake_evt_i = 3'(1 << cls);
        @(negedge clk);
        wake_evt_i = '0;
    endtask

    task automatic por(input bit aux);
        @(negedge clk);
        aux_por_n = 1'b0; bus_rst_n = 1'b1; link_stat_i = !aux;
        repeat (3) @(negedge clk);
        aux_por_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [15:0] ctl(input int st, input bit en, input bit clr);
        logic [15:0] w;
        w = '0;
        w[1:0] = 2'(st);
        w[8]   = en;
        w[15]  = clr;
        return w;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int aux = 0; aux < 2; aux++) begin
            for (int ext = 0; ext < 2; ext++) begin
                ext_clk_strap_i = ext[0];
                por(aux[0]);
                // R1 / R2: state after power-on reset
                chk("R1 ctl state field", int'(reg_rdata_o[1:0]), 0);
                chk("R1 status after por", int'(reg_rdata_o[15]), 0);
                chk("R2 default enable", int'(reg_rdata_o[8]), aux);
                chk("R1 pin idle", int'(pme_n_o), 1);
                chk("R1 phy up in D0", int'(phy_pwr_dn_o), 0);
                reg_addr_i = 1'b1; #1;
                chk("R2 capability", int'(reg_rdata_o[4:0]), aux ? 31 : 15);
                reg_addr_i = 1'b0;

                // R5 R6 R7 R8 R9: sweep states, enable and classes
                for (int st = 0; st < 4; st++) begin
                    for (int en = 0; en < 2; en++) begin
                        for (int cls = 0; cls < 3; cls++) begin
                            int exp;
                            wr(1'b0, ctl(st, en[0], 1'b1));
                            @(negedge clk);
                            chk((en == 1 && st >= 2) ? "R6 phy with enable" : "R5 phy power",
                                int'(phy_pwr_dn_o), (st >= 2 && en == 0) ? 1 : 0);
                            chk("R1 state readback", int'(reg_rdata_o[1:0]), st);
                            pulse(cls);
                            exp = en * allow(st, cls, ext[0], aux[0]);
                            chk(exp != 0 ? "R7 accepted event" : "R8 ignored event",
                                int'(reg_rdata_o[15]), exp);
                            chk("R9 pin level", int'(pme_n_o), 1 - exp);
                        end
                    end
                end

                // R10: write-one-to-clear behaviour
                wr(1'b0, ctl(0, 1'b1, 1'b1));
                pulse(0);
                chk("R10 status set", int'(reg_rdata_o[15]), 1);
                wr(1'b0, ctl(0, 1'b1, 1'b0));
                chk("R10 zero write keeps", int'(reg_rdata_o[15]), 1);
                @(negedge clk);
                reg_addr_i = 1'b0; reg_wdata_i = ctl(0, 1'b1, 1'b1); reg_wr_i = 1'b1;
                wake_evt_i = 3'b001;
                @(negedge clk);
                reg_wr_i = 1'b0; wake_evt_i = '0;
                chk("R10 event beats clear", int'(reg_rdata_o[15]), 1);
                wr(1'b0, ctl(0, 1'b1, 1'b1));
                chk("R10 one write clears", int'(reg_rdata_o[15]), 0);
                chk("R9 pin released", int'(pme_n_o), 1);

                if (aux == 1) begin
                    // D3cold: bus reset held with auxiliary supply
                    for (int cls = 0; cls < 3; cls++) begin
                        int exp;
                        wr(1'b0, ctl(0, 1'b1, 1'b1));
                        @(negedge clk); bus_rst_n = 1'b0;
                        @(negedge clk);
                        pulse(cls);
                        exp = allow(4, cls, ext[0], 1'b1);
                        chk("R7 D3cold gate pin", int'(pme_n_o), 1 - exp);
                        wr(1'b0, ctl(3, 1'b0, 1'b1));
                        @(negedge clk); bus_rst_n = 1'b1;
                        repeat (2) @(negedge clk);
                        chk("R4 enable kept", int'(reg_rdata_o[8]), 1);
                        chk("R4 status kept", int'(reg_rdata_o[15]), exp);
                        chk("R4 state to D0, write ignored", int'(reg_rdata_o[1:0]), 0);
                    end
                    wr(1'b0, ctl(0, 1'b0, 1'b1));
                    @(negedge clk); bus_rst_n = 1'b0;
                    repeat (2) @(negedge clk);
                    chk("R5 D3cold no enable phy down", int'(phy_pwr_dn_o), 1);
                    @(negedge clk); bus_rst_n = 1'b1;
                    repeat (2) @(negedge clk);
                    chk("R5 D0 after release phy up", int'(phy_pwr_dn_o), 0);
                end else begin
                    wr(1'b0, ctl(2, 1'b1, 1'b1));
                    pulse(0);
                    chk("R7 fixed in D2", int'(reg_rdata_o[15]), 1);
                    @(negedge clk); bus_rst_n = 1'b0;
                    repeat (2) @(negedge clk);
                    chk("R5 off without supply", int'(phy_pwr_dn_o), 1);
                    pulse(2);
                    chk("R8 no event in off", int'(pme_n_o), 1);
                    @(negedge clk); bus_rst_n = 1'b1;
                    repeat (2) @(negedge clk);
                    chk("R3 enable cleared", int'(reg_rdata_o[8]), 0);
                    chk("R3 status cleared", int'(reg_rdata_o[15]), 0);
                    chk("R3 state D0", int'(reg_rdata_o[1:0]), 0);
                end
            end
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule